// File: doc/BRIEF.md
# Edge-Aligned PWM Timer Channel

The block is a free-running up-counter with a programmable modulo, plus one output-compare channel that drives an edge-aligned PWM pin. The counter starts at zero, counts to the modulo value and wraps to zero. The PWM period is therefore the modulo plus one clocks. For example, a modulo of 159 at a 3.2 MHz clock gives a 20 kHz wave, and a period of 256 clocks gives 12.5 kHz.

When the overflow-set enable is on, the overflow event drives the pin high. A compare match drives it low again. Because the pin is set at overflow, a compare value of zero still leaves a one-clock pulse. The only way to get 0% duty is to turn the overflow-set enable off. A separate force bit gives 100% duty.

Modulo and compare writes are unbuffered and take effect at the next clock edge. Each event also sets a sticky flag, which is cleared by a one-cycle clear strobe. Each event can raise a one-cycle interrupt pulse when its interrupt enable is set. If a new modulo is written below the current count, the counter runs on to all-ones and wraps without an overflow event.

Top module: `pwm_tmr`

## Requirements
- R1: Overflow interrupt pulses arrive exactly modulo+1 clocks apart.
- R2: With the overflow-set enable high, the pin goes high in the clock after the counter equals the modulo, and stays high for compare+1 clocks, for every compare value from 0 to modulo-1. The pin is high when the output is 1.
- R3: A compare value of 0 with the overflow-set enable high gives a pulse exactly one clock wide, not 0% duty.
- R4: With the overflow-set enable low, the pin stays low for the whole period once it has cleared. The compare interrupt still pulses once per period.
- R5: While the force bit is high, the pin is high from the next clock onward for the whole period, whatever the compare value.
- R6: When compare equals modulo, overflow and compare fall in the same clock. The set action wins, and the pin stays high for the full period.
- R7: Each flag is set by its event and stays set until a clear strobe is given in a clock with no new event. A clear strobe drops the flag in the next clock.
- R8: An interrupt output is a single-clock pulse. It is issued only while its enable is high, and its flag is set in the same clock. With the enable low, no pulse appears, but the flag is still set.
- R9: After reset, the pin, both flags and both interrupts are low, the counter is 0 and the modulo is all-ones. The first overflow flag therefore appears 2^CNT_W clocks after reset.
- R10: A compare write takes effect from the next clock edge, within the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_we_i | input | 1 | Modulo write strobe |
| mod_wdata_i | input | CNT_W | Modulo write value |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | CNT_W | Compare write value |
| ovf_set_en_i | input | 1 | Overflow sets the pin when high |
| force_max_i | input | 1 | Force 100% duty |
| ovf_irq_en_i | input | 1 | Overflow interrupt enable |
| cmp_irq_en_i | input | 1 | Compare interrupt enable |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| cmp_clr_i | input | 1 | Compare flag clear strobe |
| pwm_o | output | 1 | PWM pin level |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare flag |
| ovf_irq_o | output | 1 | Overflow interrupt pulse |
| cmp_irq_o | output | 1 | Compare interrupt pulse |

## Verification
A wrong count or modulo register shows within one period: the spacing between overflow pulses changes, and the high time of the pin shifts away from compare+1. A wrong set/clear priority in the channel register shows in the first period as a stray one-clock pulse, a missing pulse, or a pin stuck high. A flag that leaks or clears early is caught in the clocks just after its event or its clear strobe, because those are sampled cycle by cycle.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  typedef enum logic [1:0] {
    PIN_HOLD = 2'd0,
    PIN_SET  = 2'd1,
    PIN_CLR  = 2'd2
  } pin_act_e;
endpackage

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mod_we_i,
  input  logic [CNT_W-1:0] mod_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o
);
  localparam logic [CNT_W-1:0] MOD_RST = '1;

  logic [CNT_W-1:0] cnt_q, mod_q;

  assign ovf_evt_o = (cnt_q == mod_q);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mod_q <= MOD_RST;
    end else begin
      cnt_q <= ovf_evt_o ? '0 : cnt_q + 1'b1;
      if (mod_we_i) mod_q <= mod_wdata_i;
    end
  end
endmodule

// File: rtl/pwm_tmr_channel.sv
module pwm_tmr_channel #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_evt_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             set_en_i,
  input  logic             force_i,
  output logic             cmp_evt_o,
  output logic             pwm_o
);
  import pwm_tmr_pkg::*;

  logic [CNT_W-1:0] cmp_q;
  logic             pin_q;
  pin_act_e         act;

  assign cmp_evt_o = (cnt_i == cmp_q);

  // overflow-set outranks compare-clear when both land together
  always_comb begin
    if (force_i || (ovf_evt_i && set_en_i)) act = PIN_SET;
    else if (cmp_evt_o)                     act = PIN_CLR;
    else                                    act = PIN_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      pin_q <= 1'b0;
    end else begin
      if (cmp_we_i) cmp_q <= cmp_wdata_i;
      unique case (act)
        PIN_SET: pin_q <= 1'b1;
        PIN_CLR: pin_q <= 1'b0;
        default: pin_q <= pin_q;
      endcase
    end
  end

  assign pwm_o = pin_q;
endmodule

// File: rtl/pwm_tmr_flag.sv
module pwm_tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= evt_i | (flag_q & ~clr_i);
      irq_q  <= evt_i & irq_en_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/pwm_tmr.sv
module pwm_tmr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mod_we_i,
  input  logic [CNT_W-1:0] mod_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             ovf_set_en_i,
  input  logic             force_max_i,
  input  logic             ovf_irq_en_i,
  input  logic             cmp_irq_en_i,
  input  logic             ovf_clr_i,
  input  logic             cmp_clr_i,
  output logic             pwm_o,
  output logic             ovf_flag_o,
  output logic             cmp_flag_o,
  output logic             ovf_irq_o,
  output logic             cmp_irq_o
);
  localparam int unsigned N_EVT = 2;

  logic [CNT_W-1:0] cnt;
  logic             ovf_evt, cmp_evt;
  logic [N_EVT-1:0] evt, clr, irq_en, flag, irq;

  pwm_tmr_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mod_we_i   (mod_we_i),
    .mod_wdata_i(mod_wdata_i),
    .cnt_o      (cnt),
    .ovf_evt_o  (ovf_evt)
  );

  pwm_tmr_channel #(.CNT_W(CNT_W)) i_channel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .ovf_evt_i  (ovf_evt),
    .cmp_we_i   (cmp_we_i),
    .cmp_wdata_i(cmp_wdata_i),
    .set_en_i   (ovf_set_en_i),
    .force_i    (force_max_i),
    .cmp_evt_o  (cmp_evt),
    .pwm_o      (pwm_o)
  );

  assign evt    = {cmp_evt, ovf_evt};
  assign clr    = {cmp_clr_i, ovf_clr_i};
  assign irq_en = {cmp_irq_en_i, ovf_irq_en_i};

  for (genvar g = 0; g < N_EVT; g++) begin : g_flag
    pwm_tmr_flag i_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt[g]),
      .clr_i   (clr[g]),
      .irq_en_i(irq_en[g]),
      .flag_o  (flag[g]),
      .irq_o   (irq[g])
    );
  end

  assign ovf_flag_o = flag[0];
  assign cmp_flag_o = flag[1];
  assign ovf_irq_o  = irq[0];
  assign cmp_irq_o  = irq[1];
endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwm_o,
  input logic force_max_i,
  input logic ovf_set_en_i,
  input logic ovf_flag_o,
  input logic ovf_clr_i,
  input logic cmp_flag_o,
  input logic cmp_clr_i,
  input logic ovf_irq_o,
  input logic cmp_irq_o,
  input logic ovf_irq_en_i,
  input logic cmp_irq_en_i
);
  // R4
  pin_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> ($past(force_max_i) || $past(ovf_set_en_i)));

  // R5
  force_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_max_i |=> pwm_o);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

  // R7
  cmp_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_flag_o && !cmp_clr_i) |=> cmp_flag_o);

  // R8
  ovf_irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> ovf_flag_o);

  // R8
  cmp_irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_irq_o |-> cmp_flag_o);

  // R8
  ovf_irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_irq_en_i |=> !ovf_irq_o);

  // R8
  cmp_irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_irq_en_i |=> !cmp_irq_o);
endmodule

bind pwm_tmr pwm_tmr_chk i_pwm_tmr_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwm_o       (pwm_o),
  .force_max_i (force_max_i),
  .ovf_set_en_i(ovf_set_en_i),
  .ovf_flag_o  (ovf_flag_o),
  .ovf_clr_i   (ovf_clr_i),
  .cmp_flag_o  (cmp_flag_o),
  .cmp_clr_i   (cmp_clr_i),
  .ovf_irq_o   (ovf_irq_o),
  .cmp_irq_o   (cmp_irq_o),
  .ovf_irq_en_i(ovf_irq_en_i),
  .cmp_irq_en_i(cmp_irq_en_i)
);

// File: tb/test_pwm_tmr.sv
module test_pwm_tmr;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mod_we = 1'b0, cmp_we = 1'b0;
  logic [CNT_W-1:0] mod_wd = '0, cmp_wd = '0;
  logic             set_en = 1'b0, force_max = 1'b0;
  logic             ovf_ie = 1'b0, cmp_ie = 1'b0;
  logic             ovf_clr = 1'b0, cmp_clr = 1'b0;
  logic             pwm, ovf_flag, cmp_flag, ovf_irq, cmp_irq;

  int checks = 0, errors = 0, cycles = 0;
  int highs, cpulses, ovf_at_end, first_hi, irq_seen;

  always #2 clk = ~clk;

  pwm_tmr #(.CNT_W(CNT_W)) i_pwm_tmr (
    .clk_i(clk), .rst_ni(rst_n),
    .mod_we_i(mod_we), .mod_wdata_i(mod_wd),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd),
    .ovf_set_en_i(set_en), .force_max_i(force_max),
    .ovf_irq_en_i(ovf_ie), .cmp_irq_en_i(cmp_ie),
    .ovf_clr_i(ovf_clr), .cmp_clr_i(cmp_clr),
    .pwm_o(pwm), .ovf_flag_o(ovf_flag), .cmp_flag_o(cmp_flag),
    .ovf_irq_o(ovf_irq), .cmp_irq_o(cmp_irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_regs(input int m, input int c);
    mod_we = 1'b1; mod_wd = CNT_W'(m);
    cmp_we = 1'b1; cmp_wd = CNT_W'(c);
    @(negedge clk);
    mod_we = 1'b0; cmp_we = 1'b0;
  endtask

  // stop at the negedge where an overflow irq pulse is visible
  task automatic wait_ovf();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (ovf_irq) return;
    end
    chk("R1 overflow pulse missing", 0, 1);
  endtask

  // sample p+1 negedges starting at the current one
  task automatic measure(input int p);
    highs = 0; cpulses = 0;
    first_hi = pwm;
    for (int i = 0; i <= p; i++) begin
      if (i > 0) @(negedge clk);
      if (i < p) begin
        highs += pwm;
        cpulses += cmp_irq;
      end else begin
        ovf_at_end = ovf_irq;
      end
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 pwm at reset", pwm, 0);
    chk("R9 ovf flag at reset", ovf_flag, 0);
    chk("R9 cmp flag at reset", cmp_flag, 0);
    chk("R9 irqs at reset", ovf_irq | cmp_irq, 0);
    rst_n = 1'b1;
    for (int i = 0; i < (1 << CNT_W) - 1; i++) @(negedge clk);
    chk("R9 ovf flag before all-ones modulo", ovf_flag, 0);
    @(negedge clk);
    chk("R9 ovf flag at all-ones modulo", ovf_flag, 1);
    chk("R9 pwm stays low with set disabled", pwm, 0);

    // sweep modulo and compare
    ovf_ie = 1'b1; cmp_ie = 1'b1; set_en = 1'b1;
    for (int m = 3; m <= 6; m++) begin
      for (int c = 0; c < m; c++) begin
        @(negedge clk);
        write_regs(m, c);
        wait_ovf();
        wait_ovf();
        measure(m + 1);
        chk($sformatf("R2 width m=%0d c=%0d", m, c), highs, c + 1);
        chk($sformatf("R2 pin high after overflow m=%0d", m), first_hi, 1);
        chk($sformatf("R1 period m=%0d c=%0d", m, c), ovf_at_end, 1);
        if (c == 0) chk($sformatf("R3 zero compare pulse m=%0d", m), highs, 1);
      end
    end

    // R6 compare equals modulo
    write_regs(5, 5);
    wait_ovf(); wait_ovf();
    measure(6);
    chk("R6 overflow wins over compare", highs, 6);

    // R10 compare write lands inside the running period
    write_regs(7, 2);
    wait_ovf(); wait_ovf();
    cmp_we = 1'b1; cmp_wd = 8'd5;
    measure(8);
    cmp_we = 1'b0;
    chk("R10 compare write takes effect mid-period", highs, 6);

    // R4 zero duty
    write_regs(7, 3);
    set_en = 1'b0;
    wait_ovf(); wait_ovf();
    measure(8);
    chk("R4 zero duty highs", highs, 0);
    chk("R4 compare irq still once per period", cpulses, 1);

    // R5 force maximum
    force_max = 1'b1;
    @(negedge clk);
    chk("R5 pin one clock after force", pwm, 1);
    wait_ovf();
    measure(8);
    chk("R5 full duty", highs, 8);
    force_max = 1'b0;
    set_en = 1'b1;

    // R7 flag clear, away from events (modulo 7: next overflow 8 clocks away)
    wait_ovf();
    chk("R7 ovf flag set by event", ovf_flag, 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R7 ovf flag cleared", ovf_flag, 0);
    @(negedge clk);
    chk("R7 ovf flag stays clear", ovf_flag, 0);
    chk("R8 irq is single-cycle", ovf_irq, 0);

    // R8 gated interrupts still set flags
    ovf_ie = 1'b0;
    cmp_clr = 1'b1;
    @(negedge clk);
    cmp_clr = 1'b0;
    irq_seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      irq_seen |= ovf_irq;
    end
    chk("R8 no ovf irq while disabled", irq_seen, 0);
    chk("R8 ovf flag set while irq disabled", ovf_flag, 1);
    chk("R7 cmp flag set again by event", cmp_flag, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule